// File: doc/BRIEF.md
# Compare-Driven Toggle Burst Generator

The block produces a bounded burst of edges on one output line without any software in the timing loop. Once started, a tick counter climbs from zero up to a latched period value and then wraps to zero. Within each period the output line inverts at every tick that is a non-zero multiple of a latched sub-period value. A second counter records completed periods. The block halts itself in the same clock cycle as the final period event, so no edge can follow the last intended one.

To use it, present the period, sub-period, period count, start level and idle level, then pulse start. A busy flag covers the burst. A one-cycle done pulse marks its end, and in that cycle busy falls. The block rejects settings that cannot produce a burst (a zero sub-period, a sub-period not below the period, or a zero period count). In that case it answers with an immediate done and no edges. While the block is idle, the output follows the idle level.

Top module: `burst_toggler`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy_o and done_o are 0 and pin_o is 0.
- R2: A start_i sampled while idle, with valid settings, sets busy_o and loads pin_o with start_lvl_i after that clock edge. It also latches period, sub-period and count, and clears both counters.
- R3: While busy, the tick counter runs 0,1,...,P and then returns to 0, so each period lasts P+1 cycles. pin_o inverts after every edge whose tick value t satisfies t != 0 and t mod S == 0. That gives floor(P/S) inversions per period.
- R4: The done pulse appears exactly N*(P+1) clock edges after the edge that accepted start. busy_o falls in that same cycle.
- R5: When a sub-period match falls on the final period event (S divides P), that last inversion still happens. After done, pin_o makes no inversion; it only settles to the idle level.
- R6: done_o is high for exactly one cycle per burst or rejection.
- R7: In every cycle after one in which busy_o was low, and in which busy_o is still low, pin_o equals the idle_lvl_i value of the previous cycle.
- R8: A start with sub_i equal to 0, sub_i >= period_i, or count_i equal to 0 is rejected. done_o pulses after that edge, busy_o stays low, and pin_o makes no inversion.
- R9: A start_i pulse while busy has no effect. The running burst keeps its toggle count and its length.
- R10: Changing period_i, sub_i, count_i or start_lvl_i during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| period_i | input | CW | Period compare value P |
| sub_i | input | CW | Sub-period compare value S |
| count_i | input | NW | Number of periods N in the burst |
| start_lvl_i | input | 1 | Output level loaded at start |
| idle_lvl_i | input | 1 | Output level while idle |
| pin_o | output | 1 | Toggling output line |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst or rejection pulse |

## Verification
Two events can fall in the same cycle: the sub-period match that inverts the line, and the final period match that halts the counter. The directed case P=400, S=80 puts the fifth inversion of each period on the wrap tick. In the last period, that inversion lands in the done cycle. Random settings where S does or does not divide P exercise both alignments. Each run is judged by counting the inversions seen while busy against N*floor(P/S), and by checking the tick of every inversion. The bench then confirms that the line only settles to the idle level after done and never inverts again.

// File: rtl/burst_toggler.sv
module burst_toggler #(
  parameter int CW = 16,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] sub_i,
  input  logic [NW-1:0] count_i,
  input  logic          start_lvl_i,
  input  logic          idle_lvl_i,
  output logic          pin_o,
  output logic          busy_o,
  output logic          done_o
);

  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [NW-1:0] ONE_N = NW'(1);

  logic [CW-1:0] per_q, sub_q, tick_q, ph_q;
  logic [NW-1:0] cnt_q, ev_q;
  logic          busy_q, done_q, pin_q;

  wire cfg_ok  = (sub_i != '0) && (sub_i < period_i) && (count_i != '0);
  wire accept  = start_i && !busy_q;
  wire per_hit = busy_q && (tick_q == per_q);
  wire sub_hit = busy_q && (tick_q != '0) && (ph_q == '0);
  wire last    = per_hit && (ev_q == cnt_q - ONE_N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      sub_q  <= '0;
      cnt_q  <= '0;
      tick_q <= '0;
      ph_q   <= '0;
      ev_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (cfg_ok) begin
          per_q  <= period_i;
          sub_q  <= sub_i;
          cnt_q  <= count_i;
          tick_q <= '0;
          ph_q   <= '0;
          ev_q   <= '0;
          busy_q <= 1'b1;
          pin_q  <= start_lvl_i;
        end else begin
          done_q <= 1'b1;
          pin_q  <= idle_lvl_i;
        end
      end else if (busy_q) begin
        if (per_hit) begin
          tick_q <= '0;
          ph_q   <= '0;
          ev_q   <= ev_q + ONE_N;
        end else begin
          tick_q <= tick_q + ONE_C;
          ph_q   <= (ph_q == sub_q - ONE_C) ? '0 : ph_q + ONE_C;
        end
        if (sub_hit) pin_q <= ~pin_q;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        pin_q <= idle_lvl_i;
      end
    end
  end

  assign pin_o  = pin_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/burst_toggler_chk.sv
module burst_toggler_chk #(
  parameter int CW = 16,
  parameter int NW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [CW-1:0] period_i,
  input logic [CW-1:0] sub_i,
  input logic [NW-1:0] count_i,
  input logic          start_lvl_i,
  input logic          idle_lvl_i,
  input logic          pin_o,
  input logic          busy_o,
  input logic          done_o
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  wire good = (sub_i != '0) && (sub_i < period_i) && (count_i != '0);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(busy_o)) |-> done_o);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !busy_o && start_i && good) |=> (busy_o && pin_o == $past(start_lvl_i)));

  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !busy_o && start_i && !good) |=> (done_o && !busy_o));

  p_idle_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(busy_o) && !busy_o) |-> (pin_o == $past(idle_lvl_i)));

endmodule

bind burst_toggler burst_toggler_chk #(.CW(CW), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .period_i(period_i),
  .sub_i(sub_i), .count_i(count_i), .start_lvl_i(start_lvl_i),
  .idle_lvl_i(idle_lvl_i), .pin_o(pin_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sim_burst_toggler.sv
module sim_burst_toggler;
  localparam int CLK_NS = 10;
  localparam int CW = 16;
  localparam int NW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CW-1:0] period_i = '0;
  logic [CW-1:0] sub_i = '0;
  logic [NW-1:0] count_i = '0;
  logic start_lvl_i = 1'b0;
  logic idle_lvl_i = 1'b0;
  logic pin_o, busy_o, done_o;

  int checks = 0;
  int fails = 0;
  bit ended = 0;

  always #(CLK_NS/2) clk = ~clk;

  burst_toggler #(.CW(CW), .NW(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .period_i(period_i),
    .sub_i(sub_i), .count_i(count_i), .start_lvl_i(start_lvl_i),
    .idle_lvl_i(idle_lvl_i), .pin_o(pin_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic int exp_toggles(int p, int s, int n);
    return n * (p / s);
  endfunction

  function automatic int exp_len(int p, int n);
    return n * (p + 1);
  endfunction

  function automatic bit exp_edge(int k, int p, int s);
    int t;
    t = (k - 1) % (p + 1);
    return (t != 0) && (t % s == 0);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic run_burst(int p, int s, int n, bit sl, bit il, bit poke);
    int k, tog, donek, bad_t, dones;
    bit pb, pp;
    bit done_seen;
    idle_lvl_i = il;
    @(negedge clk);
    pp = pin_o;
    pb = busy_o;
    period_i = CW'(p); sub_i = CW'(s); count_i = NW'(n);
    start_lvl_i = sl; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    period_i = CW'($urandom_range(1, 50));
    sub_i = CW'($urandom_range(0, 50));
    count_i = NW'($urandom_range(0, 9));
    start_lvl_i = ~sl;
    check(busy_o === 1'b1, "R2 busy", busy_o, 1);
    check(pin_o === sl, "R2 start level", pin_o, sl);
    k = 0; tog = 0; donek = -1; bad_t = 0; dones = 0; done_seen = 0;
    pb = busy_o; pp = pin_o;
    while (!done_seen && k < exp_len(p, n) + 20) begin
      if (poke && k == 3 && busy_o) begin
        start_i = 1'b1; period_i = 16'd3; sub_i = 16'd1; count_i = 16'd1;
      end else start_i = 1'b0;
      @(negedge clk);
      k++;
      if (pb && pin_o !== pp) tog++;
      if (pb && ((pin_o !== pp) != exp_edge(k, p, s))) bad_t++;
      if (done_o) begin done_seen = 1; donek = k; dones++; end
      pb = busy_o; pp = pin_o;
    end
    start_i = 1'b0;
    check(donek == exp_len(p, n), "R4 length", donek, exp_len(p, n));
    check(busy_o === 1'b0, "R4 busy low at done", busy_o, 0);
    check(bad_t == 0, "R3 edge timing", bad_t, 0);
    check(tog == exp_toggles(p, s, n), poke ? "R9 toggles" : "R10 toggles", tog, exp_toggles(p, s, n));
    @(negedge clk);
    check(done_o === 1'b0, "R6 single pulse", done_o, 0);
    check(pin_o === il, "R7 idle level", pin_o, il);
    pp = pin_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pin_o !== pp || busy_o !== 1'b0 || done_o !== 1'b0) bad_t++;
    end
    check(bad_t == 0, "R5 quiet after done", bad_t, 0);
  endtask

  task automatic run_reject(int p, int s, int n, bit il);
    idle_lvl_i = il;
    @(negedge clk);
    period_i = CW'(p); sub_i = CW'(s); count_i = NW'(n);
    start_lvl_i = ~il; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o === 1'b1 && busy_o === 1'b0, "R8 reject done", {busy_o, done_o}, 1);
    check(pin_o === il, "R8 no edge", pin_o, il);
    @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0 && pin_o === il, "R6 reject pulse", done_o, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && pin_o === 1'b0, "R1 reset", {busy_o, done_o, pin_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && pin_o === 1'b0, "R1 after reset", {busy_o, done_o, pin_o}, 0);
    run_burst(400, 80, 3, 1'b0, 1'b1, 1'b0);
    run_burst(400, 133, 2, 1'b1, 1'b0, 1'b1);
    run_burst(2, 1, 1, 1'b1, 1'b1, 1'b0);
    run_burst(9, 8, 3, 1'b0, 1'b0, 1'b1);
    run_reject(400, 0, 3, 1'b1);
    run_reject(400, 400, 3, 1'b0);
    run_reject(20, 30, 2, 1'b1);
    run_reject(20, 5, 0, 1'b0);
    for (int r = 0; r < 30; r++) begin
      int p, s;
      p = $urandom_range(2, 60);
      s = $urandom_range(1, p - 1);
      run_burst(p, s, $urandom_range(1, 5), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    finish_up();
  end
endmodule